// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the two modem-side registers of a 16550-style serial port. A control register drives four handshake outputs (data terminal ready, request to send, and two general-purpose outputs) and holds a loopback switch. A status register shows four incoming handshake lines: clear to send, data set ready, ring indicator and carrier detect. Each line has a sticky change flag beside it.

Incoming lines first pass through a two-flop synchroniser. A change on a line sets its flag. The ring-indicator flag is the exception: it sets only when the ring line falls. A host read of the status register returns the current value and then clears all four flags. In loopback mode, a status read returns the control outputs wired onto the status lines instead of the pins.

The interrupt request is raised when any change flag is set and the enable input is high.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the status register reads 0xB0 (carrier, data set ready and clear to send high, no flags), the control register reads 0x08, out2_out is 1, the other control outputs are 0 and irq is 0.
- R2: A write with addr=0 stores only wdata[4:0], and the control register reads back with bits 7..5 at zero. The outputs follow the stored bits: bit0 dtr_out, bit1 rts_out, bit2 out1_out, bit3 out2_out; bit4 selects loopback.
- R3: The status layout is bit7 carrier, bit6 ring, bit5 data set ready, bit4 clear to send. A pin change shows in the status register after the second rising clock edge following it, and not after the first.
- R4: Flag bits 3, 1 and 0 (carrier, data set ready, clear to send) set on any change of their line, and stay set until a status read clears them.
- R5: Flag bit 2 sets only when the ring line goes from 1 to 0; a rising ring line leaves it unchanged.
- R6: A status read (rd_en=1, addr=1, loopback off) returns the value held before the edge and clears bits 3..0 at that edge. A change detected on the same edge as the clearing read stays set.
- R7: In loopback a status read returns out2 on bit7, out1 on bit6, dtr on bit5 and rts on bit4, with bits 3..0 at zero. Such a read does not clear the pending flags.
- R8: irq is high exactly when irq_en is high and at least one status flag is set.
- R9: Writes with addr=1 have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clearing side effect) |
| addr | input | 1 | 0 = control register, 1 = status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| cts_in | input | 1 | Clear-to-send line |
| dsr_in | input | 1 | Data-set-ready line |
| ri_in | input | 1 | Ring-indicator line |
| dcd_in | input | 1 | Carrier-detect line |
| irq_en | input | 1 | Modem interrupt enable |
| dtr_out | output | 1 | Data terminal ready |
| rts_out | output | 1 | Request to send |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A wrong flag shows on irq in the same cycle it is stored, and in the low nibble of the next status read. A wrong synchroniser state delays or advances the upper nibble by a clock, and the two-edge latency checks catch it. A read that clears too eagerly loses a change that arrives on the same edge, so the colliding-read test expects that flag on the following read. A loopback read that wrongly clears the flags only shows after loopback is turned off, so the bench reads the flags again at that point.

// File: rtl/modem_ctl_status.sv
module modem_ctl_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       ri_in,
  input  logic       dcd_in,
  input  logic       irq_en,
  output logic       dtr_out,
  output logic       rts_out,
  output logic       out1_out,
  output logic       out2_out,
  output logic       irq
);

  localparam logic [3:0] LINE_RST = 4'b1011;
  localparam logic [7:0] CTRL_RST = 8'h08;
  localparam logic [7:0] CTRL_MASK = 8'h1F;

  logic [3:0] sync_a, sync_b, delta;
  logic [7:0] ctrl;

  wire [3:0] pin_now   = {dcd_in, ri_in, dsr_in, cts_in};
  wire       loop_on   = ctrl[4];
  wire       status_rd = rd_en && addr && !loop_on;

  wire [3:0] edge_hit = {sync_a[3] ^ sync_b[3],
                         sync_b[2] & ~sync_a[2],
                         sync_a[1] ^ sync_b[1],
                         sync_a[0] ^ sync_b[0]};

  wire [3:0] loop_lines = {ctrl[3], ctrl[2], ctrl[0], ctrl[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= LINE_RST;
      sync_b <= LINE_RST;
      delta  <= '0;
      ctrl   <= CTRL_RST;
    end else begin
      sync_a <= pin_now;
      sync_b <= sync_a;
      delta  <= (status_rd ? 4'b0 : delta) | edge_hit;
      if (wr_en && !addr) ctrl <= wdata & CTRL_MASK;
    end
  end

  assign rdata    = !addr   ? ctrl :
                    loop_on ? {loop_lines, 4'b0} : {sync_b, delta};
  assign dtr_out  = ctrl[0];
  assign rts_out  = ctrl[1];
  assign out1_out = ctrl[2];
  assign out2_out = ctrl[3];
  assign irq      = irq_en && (delta != 4'b0);

endmodule

module modem_ctl_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       addr,
  input logic       irq,
  input logic       irq_en,
  input logic [7:0] rdata,
  input logic       loop_on,
  input logic [3:0] sync_a,
  input logic [3:0] sync_b,
  input logic [3:0] delta
);

  a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr && !loop_on) |=> ((delta & $past(delta)) == $past(delta)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr && !loop_on && sync_a == sync_b) |=> (delta == 4'b0));

  a_r5_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_a[2] && !sync_b[2]) |=> ($stable(delta[2]) || $fell(delta[2])));

  a_r7_loop_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr && loop_on) |-> (rdata[3:0] == 4'b0));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

endmodule

bind modem_ctl_status modem_ctl_status_chk chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .irq(irq),
  .irq_en(irq_en), .rdata(rdata), .loop_on(ctrl[4]), .sync_a(sync_a),
  .sync_b(sync_b), .delta(delta)
);

// File: tb/modem_ctl_status_test.sv
module modem_ctl_status_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, addr = 0, irq_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic cts_in = 1, dsr_in = 1, ri_in = 0, dcd_in = 1;
  logic dtr_out, rts_out, out1_out, out2_out, irq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  modem_ctl_status uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cts_in(cts_in), .dsr_in(dsr_in),
    .ri_in(ri_in), .dcd_in(dcd_in), .irq_en(irq_en), .dtr_out(dtr_out),
    .rts_out(rts_out), .out1_out(out1_out), .out2_out(out2_out), .irq(irq)
  );

  // {write value, expected read-back}
  localparam logic [15:0] CTRL_VEC [9] = '{
    16'h0000, 16'h0101, 16'h0202, 16'h0404, 16'h0808,
    16'hE707, 16'h0F0F, 16'hFF1F, 16'h0000
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] r);
    @(negedge clk); addr = a; rd_en = 1; #1 r = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(input logic a, output logic [7:0] r);
    addr = a; #1 r = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(1, v); check("R1 status reset", v, 8'hB0);
    peek(0, v); check("R1 control reset", v, 8'h08);
    check("R1 outputs reset", {4'b0, out2_out, out1_out, rts_out, dtr_out}, 8'h08);
    check("R1 irq reset", {7'b0, irq}, 8'h00);

    for (int i = 0; i < 9; i++) begin
      wr(0, CTRL_VEC[i][15:8]);
      peek(0, v); check("R2 control readback", v, CTRL_VEC[i][7:0]);
      check("R2 control pins", {4'b0, out2_out, out1_out, rts_out, dtr_out},
            {4'b0, CTRL_VEC[i][3:0]});
    end

    // R6: change detected on the same edge as a clearing read
    @(negedge clk); cts_in = 0;
    @(negedge clk); addr = 1; rd_en = 1; #1 v = rdata;
    check("R6 read before flag", v, 8'hB0);
    @(negedge clk); rd_en = 0;
    rd(1, v); check("R6 flag survives collision R4", v, 8'hA1);
    rd(1, v); check("R6 cleared after read", v, 8'hA0);

    // R4 / R8
    @(negedge clk); dsr_in = 0; settle();
    irq_en = 1; #1 check("R8 irq with flag", {7'b0, irq}, 8'h01);
    irq_en = 0; #1 check("R8 irq masked", {7'b0, irq}, 8'h00);
    irq_en = 1;
    settle(); peek(1, v); check("R4 dsr flag sticky", v, 8'h82);
    rd(1, v); check("R4 dsr read", v, 8'h82);
    #1 check("R8 irq cleared by read", {7'b0, irq}, 8'h00);
    @(negedge clk); dcd_in = 0; settle();
    rd(1, v); check("R4 dcd flag", v, 8'h08);

    // R5 ring indicator
    @(negedge clk); ri_in = 1; settle();
    peek(1, v); check("R5 ring rise no flag", v, 8'h40);
    check("R5 irq quiet on rise", {7'b0, irq}, 8'h00);
    @(negedge clk); ri_in = 0; settle();
    peek(1, v); check("R5 ring fall flag", v, 8'h04);

    // R9 writes to status ignored
    wr(1, 8'hFF);
    wr(1, 8'h00);
    rd(1, v); check("R9 status unchanged by write", v, 8'h04);
    rd(1, v); check("R6 flags clear", v, 8'h00);

    // R3 two-edge latency
    @(negedge clk); cts_in = 1;
    @(negedge clk); peek(1, v); check("R3 not after first edge", v, 8'h00);
    @(negedge clk); peek(1, v); check("R3 visible after second edge", v, 8'h11);

    // R7 loopback
    wr(0, 8'h1F);
    rd(1, v); check("R7 loop all", v, 8'hF0);
    wr(0, 8'h12);
    rd(1, v); check("R7 loop rts to cts", v, 8'h10);
    wr(0, 8'h19);
    rd(1, v); check("R7 loop out2 dtr", v, 8'hA0);
    wr(0, 8'h14);
    rd(1, v); check("R7 loop out1 to ring", v, 8'h40);
    wr(0, 8'h00);
    rd(1, v); check("R7 flags kept through loop reads", v, 8'h11);
    rd(1, v); check("R6 cleared after loop exit", v, 8'h10);

    finish_run();
  end
endmodule